// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Aligner

This is a purely combinational unit that sits between a 32-bit register file and a little-endian data memory that is one word wide and addressed by byte. It has two independent halves.

The store half takes the low offset bits of the effective address, a store size code and the register operand. It produces the word to present on the memory write bus, with the active bytes copied into every lane, and a per-byte write-enable mask. The load half takes the word read from memory, the low offset bits, and a load code that gives both the size and the extension kind. It returns the selected byte, halfword or word, moved down to bit 0 and extended with the sign bit or with zeros.

Accesses that are not naturally aligned are flagged. For such a store no byte is enabled. For such a load the result is forced to zero. The unit does not generate addresses, contains no memory and takes no trap.

Top module: `lsa_byte_lane`

## Requirements
- R1: A byte load at offset k (k = 0..3) takes word bits 8k+7..8k, so offset 0 selects bits 7:0.
- R2: Load code 3'b000 (signed byte) fills result bits 31:8 with bit 7 of the selected byte. Code 3'b100 (unsigned byte) fills them with zeros.
- R3: A halfword load takes bits 15:0 at offset 0 and bits 31:16 at offset 2. Code 3'b001 sign-extends from bit 15 and code 3'b101 zero-extends.
- R4: A word load (code 3'b010) at offset 0 returns the memory word unchanged.
- R5: A byte store (code 3'b000) drives source bits 7:0 into all four lanes of the write word and enables only lane 4'b0001 << offset. Source bits 31:8 have no effect on the write word.
- R6: A halfword store (code 3'b001) drives source bits 15:0 into both halves of the write word. It enables 4'b0011 at offset 0 and 4'b1100 at offset 2, and source bits 31:16 have no effect.
- R7: A word store (code 3'b010) at offset 0 drives the source unchanged and enables 4'b1111.
- R8: A halfword access at an odd offset, or a word access at a nonzero offset, raises that side's misaligned output. On the store side all enables are then 0; on the load side the result is 0.
- R9: Codes that name no access (load 3'b011, 3'b110, 3'b111; store 3'b011 through 3'b111) give enables 4'b0000, a write word of 0, a load result of 0 and no misaligned flag.
- R10: With memory word 0x00000180, a signed byte load returns 0x00000001 at offset 1 and 0xFFFFFF80 at offset 0. Storing 0xFFFFFF80 as a byte at offset 2 and merging by the enables gives 0x00800180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_funct3 | input | 3 | Store size code |
| st_off | input | 2 | Low byte-offset bits of the store address |
| st_data | input | 32 | Register operand to store |
| st_wdata | output | 32 | Lane-replicated write word |
| st_be | output | 4 | Per-byte write enables, bit i for bits 8i+7..8i |
| st_misaligned | output | 1 | Store offset does not fit its size |
| ld_funct3 | input | 3 | Load size and extension code |
| ld_off | input | 2 | Low byte-offset bits of the load address |
| ld_word | input | 32 | Word read from memory |
| ld_result | output | 32 | Positioned and extended load value |
| ld_misaligned | output | 1 | Load offset does not fit its size |

## Verification
The hardest case to reach is a sign bit taken from the wrong lane. A word whose bytes all share the same top bit cannot expose it. The stimulus therefore uses words whose lane top bits alternate, and their complements, under every code and offset, so each lane's sign bit differs from its neighbours' in both polarities. Random source words with busy upper bits show that those bits never leak into a sub-word write. The R10 sequence checks the store result through a read-modify-write merge built from the enables.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_NONE = 2'd3
   } size_e;

   function automatic size_e load_size(input logic [2:0] code);
      case (code)
         3'b000, 3'b100: return SZ_BYTE;
         3'b001, 3'b101: return SZ_HALF;
         3'b010:         return SZ_WORD;
         default:        return SZ_NONE;
      endcase
   endfunction

   function automatic size_e store_size(input logic [2:0] code);
      case (code)
         3'b000:  return SZ_BYTE;
         3'b001:  return SZ_HALF;
         3'b010:  return SZ_WORD;
         default: return SZ_NONE;
      endcase
   endfunction

   function automatic logic load_signed(input logic [2:0] code);
      return ~code[2];
   endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
   import lsa_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  size_e            size,
   input  logic [OFF_W-1:0] off,
   output logic             misaligned
);

   always_comb begin
      case (size)
         SZ_HALF: misaligned = off[0];
         SZ_WORD: misaligned = |off;
         default: misaligned = 1'b0;
      endcase
   end

endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
   import lsa_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit REPLICATE = 1'b1,
   localparam int LANES    = DATA_W / 8,
   localparam int OFF_W    = $clog2(LANES)
) (
   input  size_e             size,
   input  logic [OFF_W-1:0]  off,
   input  logic              misaligned,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] src;
      logic       hit;

      always_comb begin
         case (size)
            SZ_BYTE: begin
               src = data[7:0];
               hit = (off == OFF_W'(i));
            end
            SZ_HALF: begin
               src = data[8*(i%2) +: 8];
               hit = (off[OFF_W-1:1] == (OFF_W-1)'(i/2));
            end
            SZ_WORD: begin
               src = data[8*i +: 8];
               hit = 1'b1;
            end
            default: begin
               src = 8'h00;
               hit = 1'b0;
            end
         endcase
      end

      assign be[i] = hit & ~misaligned;

      if (REPLICATE) begin : g_copy
         assign wdata[8*i +: 8] = src;
      end else begin : g_gate
         assign wdata[8*i +: 8] = be[i] ? src : 8'h00;
      end
   end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  size_e             size,
   input  logic              sign_ext,
   input  logic [OFF_W-1:0]  off,
   input  logic              misaligned,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] result
);

   logic [7:0]  byte_v;
   logic [15:0] half_v;

   always_comb begin
      byte_v = word[{off, 3'b000} +: 8];
      half_v = word[{off[OFF_W-1:1], 4'b0000} +: 16];
      case (size)
         SZ_BYTE: result = {{(DATA_W-8){sign_ext & byte_v[7]}}, byte_v};
         SZ_HALF: result = {{(DATA_W-16){sign_ext & half_v[15]}}, half_v};
         SZ_WORD: result = word;
         default: result = '0;
      endcase
      if (misaligned) begin
         result = '0;
      end
   end

endmodule

// File: rtl/lsa_byte_lane.sv
module lsa_byte_lane
   import lsa_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit REPLICATE = 1'b1,
   localparam int LANES    = DATA_W / 8,
   localparam int OFF_W    = $clog2(LANES)
) (
   input  logic [2:0]        st_funct3,
   input  logic [OFF_W-1:0]  st_off,
   input  logic [DATA_W-1:0] st_data,
   output logic [DATA_W-1:0] st_wdata,
   output logic [LANES-1:0]  st_be,
   output logic              st_misaligned,
   input  logic [2:0]        ld_funct3,
   input  logic [OFF_W-1:0]  ld_off,
   input  logic [DATA_W-1:0] ld_word,
   output logic [DATA_W-1:0] ld_result,
   output logic              ld_misaligned
);

   if (DATA_W != 32) begin : g_width_bad
      $error("lsa_byte_lane: size codes cover byte, half and word of a 32-bit word only");
   end

   size_e st_size;
   size_e ld_size;

   assign st_size = store_size(st_funct3);
   assign ld_size = load_size(ld_funct3);

   lsa_align_check #(.OFF_W(OFF_W)) i_st_align (
      .size       (st_size),
      .off        (st_off),
      .misaligned (st_misaligned)
   );

   lsa_align_check #(.OFF_W(OFF_W)) i_ld_align (
      .size       (ld_size),
      .off        (ld_off),
      .misaligned (ld_misaligned)
   );

   lsa_store_lanes #(.DATA_W(DATA_W), .REPLICATE(REPLICATE)) i_store (
      .size       (st_size),
      .off        (st_off),
      .misaligned (st_misaligned),
      .data       (st_data),
      .wdata      (st_wdata),
      .be         (st_be)
   );

   lsa_load_extract #(.DATA_W(DATA_W)) i_load (
      .size       (ld_size),
      .sign_ext   (load_signed(ld_funct3)),
      .off        (ld_off),
      .misaligned (ld_misaligned),
      .word       (ld_word),
      .result     (ld_result)
   );

endmodule

// File: rtl/lsa_byte_lane_chk.sv
module lsa_byte_lane_chk #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input logic [2:0]        st_funct3,
   input logic [OFF_W-1:0]  st_off,
   input logic [DATA_W-1:0] st_data,
   input logic [DATA_W-1:0] st_wdata,
   input logic [LANES-1:0]  st_be,
   input logic              st_misaligned,
   input logic [2:0]        ld_funct3,
   input logic [OFF_W-1:0]  ld_off,
   input logic [DATA_W-1:0] ld_word,
   input logic [DATA_W-1:0] ld_result,
   input logic              ld_misaligned
);

   always_comb begin
      if (!$isunknown({st_funct3, st_off, st_data, ld_funct3, ld_off, ld_word})) begin
         // R8
         st_mis_no_enable_chk: assert (!st_misaligned || st_be == '0);
         // R8
         ld_mis_zero_chk: assert (!ld_misaligned || ld_result == '0);
         // R5
         byte_single_lane_chk: assert (st_funct3 != 3'b000 || $countones(st_be) == 1);
         // R6
         half_lane_pair_chk: assert (st_funct3 != 3'b001 ||
                                     st_be == 4'b0011 || st_be == 4'b1100 || st_be == 4'b0000);
         // R7
         word_store_pass_chk: assert (st_funct3 != 3'b010 || st_wdata == st_data);
         // R2
         lbu_upper_zero_chk: assert (ld_funct3 != 3'b100 || ld_result[DATA_W-1:8] == '0);
         // R2
         lb_sign_fill_chk: assert (ld_funct3 != 3'b000 ||
                                   ld_result[DATA_W-1:8] == {(DATA_W-8){ld_result[7]}});
         // R4
         word_load_pass_chk: assert (ld_funct3 != 3'b010 || ld_off != '0 || ld_result == ld_word);
         // R9
         bad_store_code_chk: assert (st_funct3 inside {3'b000, 3'b001, 3'b010} ||
                                     (st_be == '0 && !st_misaligned));
      end
   end

endmodule

bind lsa_byte_lane lsa_byte_lane_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_lsa_byte_lane.sv
module test_lsa_byte_lane;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  st_funct3 = '0;
   logic [1:0]  st_off = '0;
   logic [31:0] st_data = '0;
   logic [31:0] st_wdata;
   logic [3:0]  st_be;
   logic        st_misaligned;
   logic [2:0]  ld_funct3 = '0;
   logic [1:0]  ld_off = '0;
   logic [31:0] ld_word = '0;
   logic [31:0] ld_result;
   logic        ld_misaligned;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsa_byte_lane i_lsa_byte_lane (
      .st_funct3     (st_funct3),
      .st_off        (st_off),
      .st_data       (st_data),
      .st_wdata      (st_wdata),
      .st_be         (st_be),
      .st_misaligned (st_misaligned),
      .ld_funct3     (ld_funct3),
      .ld_off        (ld_off),
      .ld_word       (ld_word),
      .ld_result     (ld_result),
      .ld_misaligned (ld_misaligned)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
      end
   endtask

   // Behavioural model of the store side
   function automatic void model_store(input logic [2:0] f, input logic [1:0] off, input logic [31:0] d,
                                       output logic [31:0] wd, output logic [3:0] be,
                                       output logic mis, output string req);
      int o = int'(off);
      mis = 1'b0; be = 4'b0000; wd = 32'h0;
      case (f)
         3'b000: begin req = "R5"; wd = {4{d[7:0]}}; be = 4'b0001 << o; end
         3'b001: begin req = "R6"; wd = {2{d[15:0]}}; mis = (o % 2) != 0;
                       be = (o >= 2) ? 4'b1100 : 4'b0011; end
         3'b010: begin req = "R7"; wd = d; mis = o != 0; be = 4'b1111; end
         default: req = "R9";
      endcase
      if (mis) begin be = 4'b0000; req = "R8"; end
   endfunction

   // Behavioural model of the load side
   function automatic void model_load(input logic [2:0] f, input logic [1:0] off, input logic [31:0] w,
                                      output logic [31:0] r, output logic mis, output string req);
      int o = int'(off);
      logic [31:0] sh = w >> (8 * o);
      mis = 1'b0; r = 32'h0;
      case (f)
         3'b000: begin req = (o == 0) ? "R2" : "R1"; r = $unsigned(32'($signed(sh[7:0]))); end
         3'b100: begin req = (o == 0) ? "R2" : "R1"; r = {24'h0, sh[7:0]}; end
         3'b001: begin req = "R3"; mis = (o % 2) != 0; r = $unsigned(32'($signed(sh[15:0]))); end
         3'b101: begin req = "R3"; mis = (o % 2) != 0; r = {16'h0, sh[15:0]}; end
         3'b010: begin req = "R4"; mis = o != 0; r = w; end
         default: req = "R9";
      endcase
      if (mis) begin r = 32'h0; req = "R8"; end
   endfunction

   task automatic apply(input logic [2:0] sf, input logic [1:0] so, input logic [31:0] sd,
                        input logic [2:0] lf, input logic [1:0] lo, input logic [31:0] lw);
      logic [31:0] e_wd, e_r;
      logic [3:0]  e_be;
      logic        e_sm, e_lm;
      string       sreq, lreq;
      @(posedge clk);
      #1;
      st_funct3 = sf; st_off = so; st_data = sd;
      ld_funct3 = lf; ld_off = lo; ld_word = lw;
      model_store(sf, so, sd, e_wd, e_be, e_sm, sreq);
      model_load(lf, lo, lw, e_r, e_lm, lreq);
      @(negedge clk);
      check(sreq, "st_wdata", st_wdata, e_wd);
      check(sreq, "st_be", {28'h0, st_be}, {28'h0, e_be});
      check(sreq, "st_misaligned", {31'h0, st_misaligned}, {31'h0, e_sm});
      check(lreq, "ld_result", ld_result, e_r);
      check(lreq, "ld_misaligned", {31'h0, ld_misaligned}, {31'h0, e_lm});
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] pats[6];
      logic [31:0] mem;
      pats[0] = 32'h80FF7F01; pats[1] = 32'h7F0080FE; pats[2] = 32'h807F807F;
      pats[3] = 32'h7F807F80; pats[4] = 32'hFFFFFFFF; pats[5] = 32'h00000000;

      repeat (3) @(posedge clk);
      // Idle inputs while held in reset: byte store at offset 0 of zero, signed byte load of zero (R5, R2)
      @(negedge clk);
      check("R5", "idle st_be", {28'h0, st_be}, 32'h1);
      check("R2", "idle ld_result", ld_result, 32'h0);
      rst_n = 1'b1;

      // R10 worked example
      apply(3'b000, 2'd2, 32'hFFFFFF80, 3'b000, 2'd1, 32'h00000180);
      check("R10", "lb offset1", ld_result, 32'h00000001);
      apply(3'b000, 2'd2, 32'hFFFFFF80, 3'b000, 2'd0, 32'h00000180);
      check("R10", "lb offset0", ld_result, 32'hFFFFFF80);
      mem = 32'h00000180;
      for (int b = 0; b < 4; b++) if (st_be[b]) mem[8*b +: 8] = st_wdata[8*b +: 8];
      check("R10", "merged word", mem, 32'h00800180);

      // Sweep every code and offset with lane-alternating sign bits (R1..R9)
      for (int f = 0; f < 8; f++)
         for (int o = 0; o < 4; o++)
            for (int p = 0; p < 6; p++)
               apply(3'(f), 2'(o), ~pats[p], 3'(f), 2'(o), pats[p]);

      // Random words: upper source bits must not leak into sub-word stores (R5, R6)
      for (int n = 0; n < 200; n++)
         apply(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom,
               3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom);

      finish_run();
   end

endmodule